// File: doc/BRIEF.md
# ALU With Programmable Carry Policy

This block is a 32-bit arithmetic and logic unit that keeps one persistent carry flag across operations. Each opcode is decoded into four independent controls: a base operation (add, AND, OR or XOR), a flag that complements the B operand, a selector for the carry fed into the operation, and a policy for the next value of the carry flag. Subtraction is an add of the complemented B operand. The carry flag then holds a borrow for subtract-style opcodes, so multi-word add and subtract chains can be built from a start opcode followed by carry-consuming opcodes.

The result and the `c32` flag are combinational functions of the operands, the opcode and the current carry flag. The carry flag is the only state. It changes on a clock edge only while `en` is high. The adder is built from equal carry-linked segments (16 bits wide by default), so a carry crosses the segment boundary before it reaches bit 31. For add-based opcodes, `c32` is the carry out of the most significant bit. For logic opcodes, `c32` is the carry that was fed in. For every opcode that complements B, `c32` is inverted once more after the carry flag update has been chosen.

Top module: `alu_cc_core`

## Requirements
- R1: While `rst_n` is low, `carry_q` is 0.
- R2: Opcode 0 (add) gives `result` = A+B modulo 2^32. It sets `c32` and the next carry to the carry out of bit 31.
- R3: Opcode 1 (add with carry) gives `result` = A+B+`carry_q`. It sets `c32` and the next carry to the carry out of bit 31.
- R4: Opcode 2 (subtract) gives `result` = A−B modulo 2^32. It sets `c32` and the next carry to 1 exactly when A < B unsigned, which is a borrow.
- R5: Opcode 3 (subtract with borrow) gives `result` = A−B−`carry_q`. It sets `c32` and the next carry to 1 exactly when A < B+`carry_q`. Chains of opcode 0 then 1, or of opcode 2 then 3, give exact 64-bit sums and differences.
- R6: Opcodes 4, 5 and 6 give A AND B, A OR B and A XOR B. For these, `c32` equals `carry_q` and the carry is held.
- R7: Opcode 7 (clear carry) gives A OR B. It drives `c32` to 0 and clears the carry.
- R8: Opcode 8 gives A AND NOT B. It holds the carry and drives `c32` to NOT `carry_q`.
- R9: Opcode 9 (set carry) gives A XOR B. It drives `c32` to 1 and sets the carry.
- R10: While `en` is low, `carry_q` does not change. `result` and `c32` are still computed.
- R11: Opcodes 10 to 15 give A OR B. They hold the carry and drive `c32` to `carry_q`.
- R12: An add carry that is produced below bit 16 propagates across the segment boundary into the upper half and out of bit 31.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Allows the carry flag to update on this edge |
| opcode | input | 4 | Operation select |
| a | input | 32 | Operand A |
| b | input | 32 | Operand B |
| result | output | 32 | Combinational result |
| c32 | output | 1 | Carry/borrow flag for this operation |
| carry_q | output | 1 | Persistent carry flag |

## Verification
On every cycle, the checker confirms the following: the 33-bit add outcome, the borrow flag of plain subtract, `c32` tracking the carry flag for logic opcodes, the forced clear and set of the carry, and carry stability while disabled. Only the bench scenarios can show that carry-consuming opcodes compose into exact 64-bit chains. The same holds for the segment-boundary propagation cases, the undefined opcodes and the inverted `c32` of AND-NOT.

// File: rtl/alu_cc_pkg.sv
package alu_cc_pkg;
   localparam int OPC_W = 4;

   typedef enum logic [1:0] {OP_ADD = 2'd0, OP_AND = 2'd1, OP_OR = 2'd2, OP_XOR = 2'd3} base_op_t;
   typedef enum logic [1:0] {CIN_ZERO = 2'd0, CIN_ONE = 2'd1, CIN_PREV = 2'd2, CIN_NPREV = 2'd3} cin_sel_t;
   typedef enum logic [1:0] {CO_HOLD = 2'd0, CO_ZERO = 2'd1, CO_CALC = 2'd2, CO_NCALC = 2'd3} cout_sel_t;

   typedef struct packed {
      base_op_t  op;
      logic      inv_b;
      cin_sel_t  cin;
      cout_sel_t cout;
   } alu_ctl_t;

   localparam logic [OPC_W-1:0] OPC_ADD  = 4'd0;
   localparam logic [OPC_W-1:0] OPC_ADDC = 4'd1;
   localparam logic [OPC_W-1:0] OPC_SUB  = 4'd2;
   localparam logic [OPC_W-1:0] OPC_SUBB = 4'd3;
   localparam logic [OPC_W-1:0] OPC_AND  = 4'd4;
   localparam logic [OPC_W-1:0] OPC_OR   = 4'd5;
   localparam logic [OPC_W-1:0] OPC_XOR  = 4'd6;
   localparam logic [OPC_W-1:0] OPC_CLC  = 4'd7;
   localparam logic [OPC_W-1:0] OPC_ANDN = 4'd8;
   localparam logic [OPC_W-1:0] OPC_SETC = 4'd9;
endpackage

// File: rtl/alu_cc_decode.sv
module alu_cc_decode
   import alu_cc_pkg::*;
(
   input  logic [OPC_W-1:0] opcode,
   output alu_ctl_t         ctl
);
   always_comb begin
      unique case (opcode)
         OPC_ADD:  ctl = '{op: OP_ADD, inv_b: 1'b0, cin: CIN_ZERO,  cout: CO_CALC};
         OPC_ADDC: ctl = '{op: OP_ADD, inv_b: 1'b0, cin: CIN_PREV,  cout: CO_CALC};
         OPC_SUB:  ctl = '{op: OP_ADD, inv_b: 1'b1, cin: CIN_ONE,   cout: CO_NCALC};
         OPC_SUBB: ctl = '{op: OP_ADD, inv_b: 1'b1, cin: CIN_NPREV, cout: CO_NCALC};
         OPC_AND:  ctl = '{op: OP_AND, inv_b: 1'b0, cin: CIN_PREV,  cout: CO_HOLD};
         OPC_OR:   ctl = '{op: OP_OR,  inv_b: 1'b0, cin: CIN_PREV,  cout: CO_HOLD};
         OPC_XOR:  ctl = '{op: OP_XOR, inv_b: 1'b0, cin: CIN_PREV,  cout: CO_HOLD};
         OPC_CLC:  ctl = '{op: OP_OR,  inv_b: 1'b0, cin: CIN_ZERO,  cout: CO_ZERO};
         OPC_ANDN: ctl = '{op: OP_AND, inv_b: 1'b1, cin: CIN_PREV,  cout: CO_HOLD};
         OPC_SETC: ctl = '{op: OP_XOR, inv_b: 1'b0, cin: CIN_ONE,   cout: CO_CALC};
         default:  ctl = '{op: OP_OR,  inv_b: 1'b0, cin: CIN_PREV,  cout: CO_HOLD};
      endcase
   end
endmodule

// File: rtl/alu_cc_adder.sv
module alu_cc_adder #(
   parameter int WIDTH = 32,
   parameter int SEG_W = 16
) (
   input  logic [WIDTH-1:0] x,
   input  logic [WIDTH-1:0] y,
   input  logic             cin,
   output logic [WIDTH-1:0] sum,
   output logic             cout
);
   localparam int NSEG = WIDTH / SEG_W;

   if (SEG_W < 1 || SEG_W > WIDTH || (WIDTH % SEG_W) != 0) begin : g_bad_seg
      $error("alu_cc_adder: SEG_W must divide WIDTH");
   end

   logic [NSEG:0] link;
   assign link[0] = cin;

   if (NSEG == 1) begin : g_flat
      assign {link[1], sum} = {1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, cin};
   end else begin : g_chain
      for (genvar s = 0; s < NSEG; s++) begin : g_seg
         assign {link[s+1], sum[s*SEG_W +: SEG_W]} =
            {1'b0, x[s*SEG_W +: SEG_W]} + {1'b0, y[s*SEG_W +: SEG_W]} +
            {{SEG_W{1'b0}}, link[s]};
      end
   end

   assign cout = link[NSEG];
endmodule

// File: rtl/alu_cc_logic.sv
module alu_cc_logic
   import alu_cc_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  base_op_t         op,
   input  logic [WIDTH-1:0] x,
   input  logic [WIDTH-1:0] y,
   output logic [WIDTH-1:0] r
);
   always_comb begin
      unique case (op)
         OP_AND:  r = x & y;
         OP_OR:   r = x | y;
         OP_XOR:  r = x ^ y;
         default: r = '0;
      endcase
   end
endmodule

// File: rtl/alu_cc_core.sv
module alu_cc_core
   import alu_cc_pkg::*;
#(
   parameter int WIDTH = 32,
   parameter int SEG_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [3:0]       opcode,
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   output logic [WIDTH-1:0] result,
   output logic             c32,
   output logic             carry_q
);
   if (WIDTH < 2) begin : g_bad_width
      $error("alu_cc_core: WIDTH must be at least 2");
   end

   alu_ctl_t         ctl;
   logic [WIDTH-1:0] b_eff, add_sum, log_res;
   logic             cin, add_cout, computed, carry_d;

   alu_cc_decode u_dec (.opcode(opcode), .ctl(ctl));

   assign b_eff = ctl.inv_b ? ~b : b;

   always_comb begin
      unique case (ctl.cin)
         CIN_ZERO:  cin = 1'b0;
         CIN_ONE:   cin = 1'b1;
         CIN_PREV:  cin = carry_q;
         default:   cin = ~carry_q;
      endcase
   end

   alu_cc_adder #(.WIDTH(WIDTH), .SEG_W(SEG_W)) u_add (
      .x(a), .y(b_eff), .cin(cin), .sum(add_sum), .cout(add_cout)
   );

   alu_cc_logic #(.WIDTH(WIDTH)) u_log (
      .op(ctl.op), .x(a), .y(b_eff), .r(log_res)
   );

   assign result   = (ctl.op == OP_ADD) ? add_sum : log_res;
   assign computed = (ctl.op == OP_ADD) ? add_cout : cin;

   always_comb begin
      unique case (ctl.cout)
         CO_HOLD:  carry_d = carry_q;
         CO_ZERO:  carry_d = 1'b0;
         CO_CALC:  carry_d = computed;
         default:  carry_d = ~computed;
      endcase
   end

   assign c32 = computed ^ ctl.inv_b;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  carry_q <= 1'b0;
      else if (en) carry_q <= carry_d;
   end
endmodule

// File: rtl/alu_cc_chk.sv
module alu_cc_chk #(
   parameter int WIDTH = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             en,
   input logic [3:0]       opcode,
   input logic [WIDTH-1:0] a,
   input logic [WIDTH-1:0] b,
   input logic [WIDTH-1:0] result,
   input logic             c32,
   input logic             carry_q
);
   always @(posedge clk) begin
      if (!rst_n) begin
         p_reset_clear_r1: assert (carry_q == 1'b0);
      end
   end

   p_add_sum_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (opcode == 4'd0) |-> ({c32, result} == ({1'b0, a} + {1'b0, b})));

   p_sub_borrow_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (opcode == 4'd2) |-> (c32 == (a < b)));

   p_logic_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (opcode >= 4'd4 && opcode <= 4'd6) |-> (c32 == carry_q));

   p_clear_carry_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (en && opcode == 4'd7) |=> (carry_q == 1'b0));

   p_set_carry_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (en && opcode == 4'd9) |=> (carry_q == 1'b1));

   p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!en) |=> $stable(carry_q));
endmodule

bind alu_cc_core alu_cc_chk #(.WIDTH(WIDTH)) u_chk (
   .clk(clk), .rst_n(rst_n), .en(en), .opcode(opcode), .a(a), .b(b),
   .result(result), .c32(c32), .carry_q(carry_q)
);

// File: tb/alu_cc_core_test.sv
module alu_cc_core_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        en = 1'b0;
   logic [3:0]  opcode = 4'd0;
   logic [31:0] a = '0, b = '0;
   logic [31:0] result;
   logic        c32, carry_q;

   int vectors = 0;
   int miscompares = 0;
   bit done = 1'b0;

   logic [31:0] r_s;
   logic        c_s, q_s;

   always #4 clk = ~clk;

   alu_cc_core uut (
      .clk(clk), .rst_n(rst_n), .en(en), .opcode(opcode), .a(a), .b(b),
      .result(result), .c32(c32), .carry_q(carry_q)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic step(input logic [3:0] op, input logic [31:0] x, input logic [31:0] y,
                       input logic e);
      @(negedge clk);
      opcode = op; a = x; b = y; en = e;
      #1;
      r_s = result; c_s = c32;
      @(posedge clk);
      #2;
      q_s = carry_q;
   endtask

   task automatic t_reset;
      chk("R1 reset carry", {63'd0, carry_q}, 64'd0);
      rst_n = 1'b1;
      step(4'd9, 32'd0, 32'd0, 1'b1);
      chk("R9 setc carry", {63'd0, q_s}, 64'd1);
      #1 rst_n = 1'b0;
      #1 chk("R1 async clear", {63'd0, carry_q}, 64'd0);
      @(negedge clk) rst_n = 1'b1;
   endtask

   task automatic t_add;
      step(4'd0, 32'h1234_5678, 32'h1111_1111, 1'b1);
      chk("R2 add sum", {32'd0, r_s}, 64'h2345_6789);
      chk("R2 add c32", {63'd0, c_s}, 64'd0);
      step(4'd0, 32'hFFFF_FFFF, 32'd1, 1'b1);
      chk("R2 wrap sum", {32'd0, r_s}, 64'd0);
      chk("R2 wrap c32", {63'd0, c_s}, 64'd1);
      chk("R2 wrap carry", {63'd0, q_s}, 64'd1);
      step(4'd0, 32'h0000_FFFF, 32'd1, 1'b1);
      chk("R12 half cross", {32'd0, r_s}, 64'h0001_0000);
      chk("R12 no carry", {63'd0, q_s}, 64'd0);
      step(4'd0, 32'h8000_FFFF, 32'h8000_0001, 1'b1);
      chk("R12 cross and out", {31'd0, c_s, r_s}, 64'h1_0001_0000);
   endtask

   task automatic t_addc;
      step(4'd9, 32'd0, 32'd0, 1'b1);
      step(4'd1, 32'd1, 32'd1, 1'b1);
      chk("R3 addc with carry", {32'd0, r_s}, 64'd3);
      chk("R3 carry after", {63'd0, q_s}, 64'd0);
      step(4'd1, 32'd1, 32'd1, 1'b1);
      chk("R3 addc no carry", {32'd0, r_s}, 64'd2);
   endtask

   task automatic t_sub;
      step(4'd2, 32'd5, 32'd3, 1'b1);
      chk("R4 sub", {31'd0, c_s, r_s}, 64'd2);
      chk("R4 no borrow", {63'd0, q_s}, 64'd0);
      step(4'd2, 32'd3, 32'd5, 1'b1);
      chk("R4 sub neg", {31'd0, c_s, r_s}, 64'h1_FFFF_FFFE);
      chk("R4 borrow", {63'd0, q_s}, 64'd1);
      step(4'd2, 32'd77, 32'd77, 1'b1);
      chk("R4 equal", {31'd0, c_s, r_s}, 64'd0);
   endtask

   task automatic t_chain;
      logic [63:0] x = 64'h0123_4567_89AB_CDEF;
      logic [63:0] y = 64'h0FED_CBA9_8765_4321;
      for (int i = 0; i < 20; i++) begin
         logic [64:0] s = {1'b0, x} + {1'b0, y};
         logic [63:0] d = x - y;
         logic [31:0] lo;
         step(4'd0, x[31:0], y[31:0], 1'b1);
         lo = r_s;
         step(4'd1, x[63:32], y[63:32], 1'b1);
         chk("R3 chain add", {r_s, lo}, s[63:0]);
         chk("R3 chain carry", {63'd0, q_s}, {63'd0, s[64]});
         step(4'd2, x[31:0], y[31:0], 1'b1);
         lo = r_s;
         step(4'd3, x[63:32], y[63:32], 1'b1);
         chk("R5 chain sub", {r_s, lo}, d);
         chk("R5 chain borrow", {63'd0, q_s}, {63'd0, (x < y)});
         x = {x[62:0], x[63] ^ x[62] ^ x[60] ^ x[59]} ^ {32'd0, y[63:32]};
         y = y * 64'd6364136223846793005 + 64'd1442695040888963407;
         if (i == 3) y = x;
         if (i == 7) begin x = 64'hFFFF_FFFF_FFFF_FFFF; y = 64'd1; end
      end
   endtask

   task automatic t_subb_direct;
      step(4'd9, 32'd0, 32'd0, 1'b1);
      step(4'd3, 32'd10, 32'd3, 1'b1);
      chk("R5 subb borrow in", {31'd0, c_s, r_s}, 64'd6);
      step(4'd9, 32'd0, 32'd0, 1'b1);
      step(4'd3, 32'd3, 32'd3, 1'b1);
      chk("R5 subb underflow", {31'd0, c_s, r_s}, 64'h1_FFFF_FFFF);
      chk("R5 subb carry", {63'd0, q_s}, 64'd1);
   endtask

   task automatic t_logic;
      logic [31:0] x = 32'hF0F0_AA55, y = 32'h0FF0_5A5A;
      step(4'd9, x, y, 1'b1);
      chk("R9 setc result", {31'd0, c_s, r_s}, {31'd0, 1'b1, x ^ y});
      step(4'd4, x, y, 1'b1);
      chk("R6 and", {31'd0, c_s, r_s}, {31'd0, 1'b1, x & y});
      step(4'd5, x, y, 1'b1);
      chk("R6 or", {31'd0, c_s, r_s}, {31'd0, 1'b1, x | y});
      step(4'd6, x, y, 1'b1);
      chk("R6 xor", {31'd0, c_s, r_s}, {31'd0, 1'b1, x ^ y});
      chk("R6 carry held", {63'd0, q_s}, 64'd1);
      step(4'd8, x, y, 1'b1);
      chk("R8 andn set", {31'd0, c_s, r_s}, {31'd0, 1'b0, x & ~y});
      chk("R8 held", {63'd0, q_s}, 64'd1);
      step(4'd7, x, y, 1'b1);
      chk("R7 clc", {31'd0, c_s, r_s}, {31'd0, 1'b0, x | y});
      chk("R7 cleared", {63'd0, q_s}, 64'd0);
      step(4'd6, x, y, 1'b1);
      chk("R6 xor clear", {63'd0, c_s}, 64'd0);
      step(4'd8, x, y, 1'b1);
      chk("R8 andn clear", {63'd0, c_s}, 64'd1);
   endtask

   task automatic t_enable;
      step(4'd7, 32'd0, 32'd0, 1'b1);
      step(4'd9, 32'h00FF, 32'h0F0F, 1'b0);
      chk("R10 result live", {32'd0, r_s}, 64'h0FF0);
      chk("R10 setc blocked", {63'd0, q_s}, 64'd0);
      step(4'd0, 32'hFFFF_FFFF, 32'd1, 1'b0);
      chk("R10 add blocked", {63'd0, q_s}, 64'd0);
      step(4'd9, 32'd0, 32'd0, 1'b1);
      step(4'd7, 32'd0, 32'd0, 1'b0);
      chk("R10 clc blocked", {63'd0, q_s}, 64'd1);
   endtask

   task automatic t_undef;
      for (int op = 10; op < 16; op++) begin
         step(op[3:0], 32'hA000_0003, 32'h0500_0030, 1'b1);
         chk("R11 undefined", {30'd0, q_s, c_s, r_s}, {30'd0, 1'b1, 1'b1, 32'hA500_0033});
      end
      step(4'd7, 32'd0, 32'd0, 1'b1);
      step(4'd12, 32'd1, 32'd2, 1'b1);
      chk("R11 undefined clear", {30'd0, q_s, c_s, r_s}, {30'd0, 1'b0, 1'b0, 32'd3});
   endtask

   initial begin
      #1;
      t_reset();
      t_add();
      t_addc();
      t_sub();
      t_subb_direct();
      t_chain();
      t_logic();
      t_enable();
      t_undef();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      #(8 * 150000);
      if (!done) begin
         done = 1'b1;
         miscompares++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end
endmodule